// File: doc/BRIEF.md
# Exception Entry Sequencer

This block runs the processor's entry into an exception or interrupt handler. In any cycle where a synchronous exception code is pending, or the interrupt line is raised, it picks the cause to take. It then computes everything the pipeline needs to jump into the handler: the handler address, the new status word, copies of the status word, program counter and stack register, and the cause codes that the handler reads back.

The decision is made on the inputs of one clock cycle. The results are registered and appear on the next cycle, together with a one-cycle `entryValid` pulse. The result registers keep their values until the next entry, so software state such as the saved PC stays readable after the pulse. The block does not arbitrate between interrupt sources. It receives one candidate vector with its level and only decides whether that candidate beats the current mask.

Top module: `excseq_top`

## Requirements
- R1: When `excValid` is high the exception is taken, whatever the interrupt inputs show, and `intEvt` keeps its previous value.
- R2: With the block bit (status bit 28) set, any pending exception code other than 0x1E0 is replaced by the reset code 0x000. Code 0x1E0 is taken unchanged.
- R3: With the block bit set and no exception pending, an interrupt request produces no entry, and all outputs hold.
- R4: On every entry, `savedSr` receives `srIn`, `savedR15` receives `r15In`, and `savedPc` receives `pcIn` as adjusted by R8 and R11.
- R5: On every entry, `newSr` equals `srIn` with bits 28, 29 and 30 set.
- R6: A reset entry (effective code 0x000) also clears bit 15 of `newSr`, sets bits 7:4 to 0xF, and sets `newPc` to 0xA0000000.
- R7: Codes 0x040 and 0x060 give `newPc` = `vbr` + 0x400. Every other non-reset exception gives `vbr` + 0x100.
- R8: For the trap code 0x160, 2 is added to the saved PC.
- R9: An interrupt is accepted only if `irqVecValid` is high and `irqLevel` is strictly greater than status bits 7:4. Otherwise no entry occurs.
- R10: A taken interrupt writes `irqVec` into `intEvt`, sets `newPc` to `vbr` + 0x600, and leaves `expEvt` unchanged.
- R11: If `dsFlags` bit 0 (unconditional delay slot) or bit 1 (conditional delay slot) is set, 2 is subtracted from the saved PC and `slotClear` pulses together with `entryValid`.
- R12: Every exception entry, including one escalated to reset, writes its effective code into `expEvt`.
- R13: The results of a cycle's inputs appear after one clock edge. `entryValid` is high for exactly that cycle. With no event pending, every output holds. Reset clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| excValid | input | 1 | A synchronous exception is pending |
| excCode | input | 12 | Pending exception code |
| irqReq | input | 1 | Interrupt request line |
| irqVecValid | input | 1 | The interrupt candidate carries a vector |
| irqVec | input | 12 | Interrupt candidate vector code |
| irqLevel | input | 4 | Interrupt candidate priority level |
| srIn | input | 32 | Current status register |
| vbr | input | 32 | Vector base address |
| pcIn | input | 32 | Program counter of the faulting or next instruction |
| r15In | input | 32 | Current stack register value |
| dsFlags | input | 2 | Delay-slot state: bit 0 unconditional, bit 1 conditional |
| entryValid | output | 1 | One-cycle pulse: an entry was performed |
| newPc | output | 32 | Handler address |
| newSr | output | 32 | Status register for the handler |
| savedSr | output | 32 | Saved status register |
| savedPc | output | 32 | Saved program counter |
| savedR15 | output | 32 | Saved stack register |
| expEvt | output | 12 | Exception event code |
| intEvt | output | 12 | Interrupt event code |
| slotClear | output | 1 | Pulse: delay-slot flags must be cleared |

## Verification
Some properties are checked on every cycle. Priority of exceptions over interrupts, escalation under the block bit, dropping of interrupts under that bit, the strict level-versus-mask acceptance, the three forced status bits, the interrupt vector address and the holding of outputs when idle are all checked this way. The exact handler address for each exception class, the trap and delay-slot adjustments of the saved PC, the reset-specific status changes, and the preservation of `expEvt` across interrupts depend on specific code sequences. These are shown by the bench's vector table and its directed reset and idle scenarios.

// File: rtl/excseq_pkg.sv
package excseq_pkg;

  localparam int CODE_W = 12;

  // status word bit positions that the handler and pipeline decode
  localparam int SR_FD_BIT   = 15;
  localparam int SR_BL_BIT   = 28;
  localparam int SR_RB_BIT   = 29;
  localparam int SR_MD_BIT   = 30;
  localparam int SR_MASK_LO  = 4;

  // delay slot flag positions
  localparam int DS_UNCOND   = 0;
  localparam int DS_COND     = 1;

  localparam logic [CODE_W-1:0] CODE_RESET    = 12'h000;
  localparam logic [CODE_W-1:0] CODE_TLB_LOAD = 12'h040;
  localparam logic [CODE_W-1:0] CODE_TLB_STOR = 12'h060;
  localparam logic [CODE_W-1:0] CODE_TRAP     = 12'h160;
  localparam logic [CODE_W-1:0] CODE_BL_PASS  = 12'h1E0;

  typedef enum logic [2:0] {
    KIND_NONE,
    KIND_RESET,
    KIND_TLBMISS,
    KIND_GENERAL,
    KIND_TRAP,
    KIND_IRQ
  } entryKind_e;

  typedef struct packed {
    logic       take;
    entryKind_e kind;
    logic       inSlot;
  } seqStrobe_t;

endpackage

// File: rtl/excseq_ctrl.sv
module excseq_ctrl
  import excseq_pkg::*;
#(
  parameter int MASK_W = 4
) (
  input  logic              excValid,
  input  logic [CODE_W-1:0] excCode,
  input  logic              irqReq,
  input  logic              irqVecValid,
  input  logic [MASK_W-1:0] irqLevel,
  input  logic [MASK_W-1:0] srMask,
  input  logic              srBl,
  input  logic [1:0]        dsFlags,
  output seqStrobe_t        strobe,
  output logic [CODE_W-1:0] effCode
);

  logic irqAccept;
  logic irqTake;
  logic escalate;

  // the candidate must beat the current mask strictly
  assign irqAccept = irqVecValid && (irqLevel > srMask);
  // exceptions always win; the block bit drops interrupts
  assign irqTake   = !excValid && irqReq && irqAccept && !srBl;
  // masked exceptions turn into reset, one code is exempt
  assign escalate  = srBl && (excCode != CODE_BL_PASS);
  assign effCode   = escalate ? CODE_RESET : excCode;

  always_comb begin
    strobe        = '0;
    strobe.kind   = KIND_NONE;
    strobe.inSlot = dsFlags[DS_UNCOND] | dsFlags[DS_COND];
    if (excValid) begin
      strobe.take = 1'b1;
      if (effCode == CODE_RESET)
        strobe.kind = KIND_RESET;
      else if (effCode == CODE_TLB_LOAD || effCode == CODE_TLB_STOR)
        strobe.kind = KIND_TLBMISS;
      else if (effCode == CODE_TRAP)
        strobe.kind = KIND_TRAP;
      else
        strobe.kind = KIND_GENERAL;
    end else if (irqTake) begin
      strobe.take = 1'b1;
      strobe.kind = KIND_IRQ;
    end
  end

endmodule

// File: rtl/excseq_dp.sv
module excseq_dp
  import excseq_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int          MASK_W   = 4,
  parameter logic [31:0] RESET_PC = 32'hA000_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [CODE_W-1:0] effCode,
  input  logic [CODE_W-1:0] irqVec,
  input  logic [XLEN-1:0]   srIn,
  input  logic [XLEN-1:0]   vbr,
  input  logic [XLEN-1:0]   pcIn,
  input  logic [XLEN-1:0]   r15In,
  output logic              entryValid,
  output logic [XLEN-1:0]   newPc,
  output logic [XLEN-1:0]   newSr,
  output logic [XLEN-1:0]   savedSr,
  output logic [XLEN-1:0]   savedPc,
  output logic [XLEN-1:0]   savedR15,
  output logic [CODE_W-1:0] expEvt,
  output logic [CODE_W-1:0] intEvt,
  output logic              slotClear
);

  localparam logic [XLEN-1:0] OFS_GENERAL = XLEN'(32'h100);
  localparam logic [XLEN-1:0] OFS_TLBMISS = XLEN'(32'h400);
  localparam logic [XLEN-1:0] OFS_IRQ     = XLEN'(32'h600);
  localparam logic [XLEN-1:0] INSN_BYTES  = XLEN'(2);
  localparam logic [XLEN-1:0] PC_AT_RESET = XLEN'(RESET_PC);

  logic [XLEN-1:0] srNext;
  logic [XLEN-1:0] pcNext;
  logic [XLEN-1:0] spcNext;
  logic [XLEN-1:0] slotAdj;
  logic [XLEN-1:0] trapAdj;

  always_comb begin
    srNext = srIn;
    srNext[SR_BL_BIT] = 1'b1;
    srNext[SR_RB_BIT] = 1'b1;
    srNext[SR_MD_BIT] = 1'b1;
    if (strobe.kind == KIND_RESET) begin
      srNext[SR_FD_BIT] = 1'b0;
      srNext[SR_MASK_LO +: MASK_W] = '1;
    end
  end

  always_comb begin
    unique case (strobe.kind)
      KIND_RESET:   pcNext = PC_AT_RESET;
      KIND_TLBMISS: pcNext = vbr + OFS_TLBMISS;
      KIND_IRQ:     pcNext = vbr + OFS_IRQ;
      default:      pcNext = vbr + OFS_GENERAL;
    endcase
  end

  // back up to the branch for a delay slot, skip the trap on return
  assign slotAdj = strobe.inSlot ? INSN_BYTES : '0;
  assign trapAdj = (strobe.kind == KIND_TRAP) ? INSN_BYTES : '0;
  assign spcNext = pcIn - slotAdj + trapAdj;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      entryValid <= 1'b0;
      slotClear  <= 1'b0;
      newPc      <= '0;
      newSr      <= '0;
      savedSr    <= '0;
      savedPc    <= '0;
      savedR15   <= '0;
      expEvt     <= '0;
      intEvt     <= '0;
    end else begin
      entryValid <= strobe.take;
      slotClear  <= strobe.take && strobe.inSlot;
      if (strobe.take) begin
        newPc    <= pcNext;
        newSr    <= srNext;
        savedSr  <= srIn;
        savedPc  <= spcNext;
        savedR15 <= r15In;
        if (strobe.kind == KIND_IRQ)
          intEvt <= irqVec;
        else
          expEvt <= effCode;
      end
    end
  end

endmodule

// File: rtl/excseq_top.sv
module excseq_top
  import excseq_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int          MASK_W   = 4,
  parameter logic [31:0] RESET_PC = 32'hA000_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              excValid,
  input  logic [CODE_W-1:0] excCode,
  input  logic              irqReq,
  input  logic              irqVecValid,
  input  logic [CODE_W-1:0] irqVec,
  input  logic [MASK_W-1:0] irqLevel,
  input  logic [XLEN-1:0]   srIn,
  input  logic [XLEN-1:0]   vbr,
  input  logic [XLEN-1:0]   pcIn,
  input  logic [XLEN-1:0]   r15In,
  input  logic [1:0]        dsFlags,
  output logic              entryValid,
  output logic [XLEN-1:0]   newPc,
  output logic [XLEN-1:0]   newSr,
  output logic [XLEN-1:0]   savedSr,
  output logic [XLEN-1:0]   savedPc,
  output logic [XLEN-1:0]   savedR15,
  output logic [CODE_W-1:0] expEvt,
  output logic [CODE_W-1:0] intEvt,
  output logic              slotClear
);

  seqStrobe_t        strobe;
  logic [CODE_W-1:0] effCode;

  excseq_ctrl #(.MASK_W(MASK_W)) ctrl_i (
    .excValid    (excValid),
    .excCode     (excCode),
    .irqReq      (irqReq),
    .irqVecValid (irqVecValid),
    .irqLevel    (irqLevel),
    .srMask      (srIn[SR_MASK_LO +: MASK_W]),
    .srBl        (srIn[SR_BL_BIT]),
    .dsFlags     (dsFlags),
    .strobe      (strobe),
    .effCode     (effCode)
  );

  excseq_dp #(.XLEN(XLEN), .MASK_W(MASK_W), .RESET_PC(RESET_PC)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .effCode    (effCode),
    .irqVec     (irqVec),
    .srIn       (srIn),
    .vbr        (vbr),
    .pcIn       (pcIn),
    .r15In      (r15In),
    .entryValid (entryValid),
    .newPc      (newPc),
    .newSr      (newSr),
    .savedSr    (savedSr),
    .savedPc    (savedPc),
    .savedR15   (savedR15),
    .expEvt     (expEvt),
    .intEvt     (intEvt),
    .slotClear  (slotClear)
  );

endmodule

// File: rtl/excseq_chk.sv
module excseq_chk
  import excseq_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int          MASK_W   = 4,
  parameter logic [31:0] RESET_PC = 32'hA000_0000
) (
  input logic              clk,
  input logic              rstN,
  input logic              excValid,
  input logic [CODE_W-1:0] excCode,
  input logic              irqReq,
  input logic              irqVecValid,
  input logic [CODE_W-1:0] irqVec,
  input logic [MASK_W-1:0] irqLevel,
  input logic [XLEN-1:0]   srIn,
  input logic [XLEN-1:0]   vbr,
  input logic [XLEN-1:0]   pcIn,
  input logic [XLEN-1:0]   r15In,
  input logic [1:0]        dsFlags,
  input logic              entryValid,
  input logic [XLEN-1:0]   newPc,
  input logic [XLEN-1:0]   newSr,
  input logic [XLEN-1:0]   savedSr,
  input logic [XLEN-1:0]   savedPc,
  input logic [XLEN-1:0]   savedR15,
  input logic [CODE_W-1:0] expEvt,
  input logic [CODE_W-1:0] intEvt,
  input logic              slotClear
);

  logic irqWins;
  logic irqLoses;
  assign irqWins  = !excValid && irqReq && !srIn[SR_BL_BIT] && irqVecValid &&
                    (irqLevel > srIn[SR_MASK_LO +: MASK_W]);
  assign irqLoses = !excValid && irqReq && !srIn[SR_BL_BIT] &&
                    (!irqVecValid || irqLevel <= srIn[SR_MASK_LO +: MASK_W]);

  // R1
  exc_beats_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    excValid |=> (entryValid && $stable(intEvt)));

  // R2
  bl_escalate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (excValid && srIn[SR_BL_BIT] && excCode != CODE_BL_PASS) |=>
      (expEvt == CODE_RESET && newPc == XLEN'(RESET_PC)));

  // R3
  bl_drops_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!excValid && srIn[SR_BL_BIT]) |=> !entryValid);

  // R5
  entry_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    entryValid |-> (newSr[SR_BL_BIT] && newSr[SR_RB_BIT] && newSr[SR_MD_BIT]));

  // R4
  save_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    (excValid || irqWins) |=> (savedSr == $past(srIn) && savedR15 == $past(r15In)));

  // R9
  irq_reject_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqLoses |=> !entryValid);

  // R10
  irq_vector_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqWins |=> (intEvt == $past(irqVec) && newPc == $past(vbr) + XLEN'(32'h600)
                 && $stable(expEvt)));

  // R13
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!excValid && !irqReq) |=> (!entryValid && !slotClear && $stable(newPc) &&
                                $stable(savedPc)));

  // R11
  slot_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    slotClear |-> entryValid);

endmodule

bind excseq_top excseq_chk #(.XLEN(XLEN), .MASK_W(MASK_W), .RESET_PC(RESET_PC)) chk_i (.*);

// File: tb/excseq_top_tb_top.sv
`timescale 1ns/1ps
module excseq_top_tb_top;

  localparam int NVEC = 17;
  // fields: excValid, excCode, irqReq, irqVecValid, irqVec, irqLevel, bl, mask, dsFlags
  localparam logic [37:0] VECS [NVEC] = '{
    {1'b1, 12'h040, 1'b0, 1'b0, 12'h000, 4'h0, 1'b0, 4'h0, 2'b00},
    {1'b1, 12'h060, 1'b0, 1'b0, 12'h000, 4'h0, 1'b0, 4'h0, 2'b00},
    {1'b1, 12'h0E0, 1'b0, 1'b0, 12'h000, 4'h0, 1'b0, 4'h0, 2'b00},
    {1'b1, 12'h160, 1'b0, 1'b0, 12'h000, 4'h0, 1'b0, 4'h0, 2'b00},
    {1'b1, 12'h0A0, 1'b1, 1'b1, 12'h3C0, 4'hF, 1'b0, 4'h0, 2'b00},
    {1'b0, 12'h000, 1'b1, 1'b1, 12'h320, 4'h9, 1'b0, 4'h3, 2'b00},
    {1'b0, 12'h000, 1'b1, 1'b1, 12'h340, 4'h3, 1'b0, 4'h3, 2'b00},
    {1'b0, 12'h000, 1'b1, 1'b0, 12'h360, 4'hF, 1'b0, 4'h0, 2'b00},
    {1'b1, 12'h0A0, 1'b0, 1'b0, 12'h000, 4'h0, 1'b1, 4'h0, 2'b00},
    {1'b1, 12'h1E0, 1'b0, 1'b0, 12'h000, 4'h0, 1'b1, 4'h0, 2'b00},
    {1'b0, 12'h000, 1'b1, 1'b1, 12'h380, 4'hF, 1'b1, 4'h0, 2'b00},
    {1'b1, 12'h100, 1'b0, 1'b0, 12'h000, 4'h0, 1'b0, 4'h2, 2'b01},
    {1'b1, 12'h160, 1'b0, 1'b0, 12'h000, 4'h0, 1'b0, 4'h0, 2'b10},
    {1'b1, 12'h0C0, 1'b0, 1'b0, 12'h000, 4'h0, 1'b0, 4'h0, 2'b00},
    {1'b1, 12'h000, 1'b0, 1'b0, 12'h000, 4'h0, 1'b0, 4'h5, 2'b00},
    {1'b1, 12'h040, 1'b0, 1'b0, 12'h000, 4'h0, 1'b1, 4'h0, 2'b00},
    {1'b0, 12'h000, 1'b1, 1'b1, 12'h200, 4'h4, 1'b0, 4'h3, 2'b01}
  };

  logic        clk = 1'b0;
  logic        rstN;
  logic        excValid, irqReq, irqVecValid;
  logic [11:0] excCode, irqVec;
  logic [3:0]  irqLevel;
  logic [31:0] srIn, vbr, pcIn, r15In;
  logic [1:0]  dsFlags;
  logic        entryValid, slotClear;
  logic [31:0] newPc, newSr, savedSr, savedPc, savedR15;
  logic [11:0] expEvt, intEvt;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // model state
  logic [31:0] mPc, mSr, mSsr, mSpc, mR15;
  logic [11:0] mExp, mInt;

  always #2.5 clk = ~clk;

  excseq_top dut_i (
    .clk(clk), .rstN(rstN), .excValid(excValid), .excCode(excCode),
    .irqReq(irqReq), .irqVecValid(irqVecValid), .irqVec(irqVec),
    .irqLevel(irqLevel), .srIn(srIn), .vbr(vbr), .pcIn(pcIn), .r15In(r15In),
    .dsFlags(dsFlags), .entryValid(entryValid), .newPc(newPc), .newSr(newSr),
    .savedSr(savedSr), .savedPc(savedPc), .savedR15(savedR15),
    .expEvt(expEvt), .intEvt(intEvt), .slotClear(slotClear)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic goIdle();
    excValid = 1'b0; irqReq = 1'b0; irqVecValid = 1'b0;
    excCode = '0; irqVec = '0; irqLevel = '0; dsFlags = '0;
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    done = 1'b1;
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      finishRun();
    end
  end

  initial begin
    rstN = 1'b0; goIdle();
    srIn = '0; vbr = 32'h8C00_0000; pcIn = '0; r15In = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R13: reset state
    check(entryValid == 1'b0, "R13 reset entryValid", {31'b0, entryValid}, 32'h0);
    check(newPc == 32'h0, "R13 reset newPc", newPc, 32'h0);
    check(expEvt == 12'h0 && intEvt == 12'h0, "R13 reset codes",
          {8'h0, expEvt, intEvt}, 32'h0);
    mPc = '0; mSr = '0; mSsr = '0; mSpc = '0; mR15 = '0; mExp = '0; mInt = '0;

    for (int i = 0; i < NVEC; i++) begin
      logic [37:0] v;
      logic        eV, iR, vV, bl, take, isIrq;
      logic [11:0] code, vec, eff;
      logic [3:0]  lvl, msk;
      logic [1:0]  ds;
      logic [31:0] sr, pc, r15, expPc, expSr, expSpc;
      string       pcTag;
      v = VECS[i];
      {eV, code, iR, vV, vec, lvl, bl, msk, ds} = v;
      sr  = 32'h0000_8001 | ({31'b0, bl} << 28) | ({28'b0, msk} << 4);
      pc  = 32'h0C00_1000 + 32'(i * 16);
      r15 = 32'h0D00_0000 + 32'(i);

      @(negedge clk);
      excValid = eV; excCode = code; irqReq = iR; irqVecValid = vV;
      irqVec = vec; irqLevel = lvl; dsFlags = ds; srIn = sr; pcIn = pc; r15In = r15;

      // model from the requirements
      isIrq = !eV && iR && vV && (lvl > msk) && !bl;
      take  = eV || isIrq;
      eff   = (bl && code != 12'h1E0) ? 12'h000 : code;
      expSr = sr | 32'h7000_0000;
      expSpc = pc;
      if (ds != 2'b00) expSpc = expSpc - 32'd2;
      pcTag = "R7 general vector";
      if (isIrq) begin
        expPc = vbr + 32'h600; pcTag = "R10 irq vector";
      end else if (eff == 12'h000) begin
        expPc = 32'hA000_0000; pcTag = "R6 reset vector";
        expSr = (expSr & ~32'h0000_8000) | 32'h0000_00F0;
      end else if (eff == 12'h040 || eff == 12'h060) begin
        expPc = vbr + 32'h400; pcTag = "R7 tlb vector";
      end else begin
        expPc = vbr + 32'h100;
        if (eff == 12'h160) expSpc = expSpc + 32'd2;
      end
      if (take) begin
        mPc = expPc; mSr = expSr; mSsr = sr; mSpc = expSpc; mR15 = r15;
        if (isIrq) mInt = vec; else mExp = eff;
      end

      @(negedge clk);
      check(entryValid == take, (take ? "R13 entry pulse" : "R9 R3 no entry"),
            {31'b0, entryValid}, {31'b0, take});
      check(newPc == mPc, pcTag, newPc, mPc);
      check(newSr == mSr, "R5 R6 newSr", newSr, mSr);
      check(savedSr == mSsr && savedR15 == mR15, "R4 saved sr/r15",
            savedSr ^ savedR15, mSsr ^ mR15);
      check(savedPc == mSpc, "R4 R8 R11 savedPc", savedPc, mSpc);
      check(expEvt == mExp, "R12 R2 expEvt", {20'b0, expEvt}, {20'b0, mExp});
      check(intEvt == mInt, "R10 R1 intEvt", {20'b0, intEvt}, {20'b0, mInt});
      check(slotClear == (take && ds != 2'b00), "R11 slotClear",
            {31'b0, slotClear}, {31'b0, take && ds != 2'b00});
      goIdle();
    end

    // R13: outputs hold while idle, pulse gone
    repeat (2) @(negedge clk);
    check(entryValid == 1'b0, "R13 idle no pulse", {31'b0, entryValid}, 32'h0);
    check(newPc == mPc && savedPc == mSpc, "R13 idle hold", newPc, mPc);

    // R3: interrupt under the block bit changes nothing
    srIn = 32'h1000_0000; irqReq = 1'b1; irqVecValid = 1'b1;
    irqVec = 12'h3E0; irqLevel = 4'hF; excValid = 1'b0;
    @(negedge clk);
    goIdle();
    check(entryValid == 1'b0 && intEvt == mInt, "R3 blocked irq",
          {20'b0, intEvt}, {20'b0, mInt});

    // R13: mid-run reset clears outputs
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    check(newPc == 32'h0 && savedPc == 32'h0 && expEvt == 12'h0,
          "R13 reset clears", newPc, 32'h0);
    @(negedge clk);
    finishRun();
  end

endmodule